// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked on-chip requester and an external asynchronous static RAM with 32K words of 16 bits and two byte lanes. It turns a single-cycle read or write request into the active-low chip-select, write-strobe, output-enable and lane-select waveforms the memory needs. Each strobe phase is sized as a whole number of clock cycles. The sizing comes from parameters for the clock period and for the memory's speed grade.

A request is taken only while the sequencer reports ready. Address, write data and lane mask are latched when the request is accepted and held until the access ends. Each completed access gives a one-cycle done pulse, and a read also returns its data. The write strobe is always the signal that ends a write. After every read there is one quiet cycle, so the memory's output drivers and the controller's write drivers are never on together. A request with an empty lane mask completes at once and touches no memory pin.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and straight after reset, `ready` is 1, `done` is 0, every active-low strobe is 1 and `sram_dq_oe` is 0.
- R2: A read with a non-zero mask holds `sram_ce_n` and `sram_oe_n` at 0 and `sram_we_n` at 1 for exactly the read-phase length. These pins change on the clock edge that accepts the request.
- R3: On the last read-phase cycle, the sequencer captures `sram_dq_in` into `rdata`, and `rdata` is valid while `done` is 1. A byte lane whose mask bit is 0 reads as 8'h00.
- R4: A write runs in three stages. There is one setup cycle with `sram_ce_n` and the lane selects low and `sram_we_n` high. Then `sram_we_n` is low for the pulse length. Then there is one hold cycle in which `sram_we_n` is back to 1 while `sram_ce_n` and the lane selects are still low.
- R5: `sram_dq_oe` is 1 only while `sram_we_n` is 0. `sram_oe_n` is 1 during every write cycle.
- R6: From acceptance to the end of the access, `sram_addr`, `sram_dq_out` and the lane selects stay equal to the accepted address, write data and mask.
- R7: After a read there is exactly one cycle with all strobes high, `sram_dq_oe` 0 and `ready` 0. The done pulse of the read falls in this cycle.
- R8: `ready` is 1 only in the idle state, and requests seen while `ready` is 0 are ignored. `done` rises for one cycle per accepted access. A write's done cycle is idle, so a request present then is accepted in that same cycle.
- R9: A request with `req_mask` = 0 leaves all strobes high. It raises `done` in the next cycle and keeps `ready` at 1.
- R10: `req_mask[0]` drives `sram_be_n[0]`, the lane of data bits 7:0. `req_mask[1]` drives `sram_be_n[1]`, the lane of data bits 15:8. Both lane selects are active low.
- R11: The read phase lasts ceil(access time / clock period) + 1 cycles. The write pulse lasts ceil(max(pulse width, data setup) / clock period) cycles, and at least one. With a 20 ns clock and the fastest grade, these are 2 cycles and 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken when ready is 1 |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane mask, bit 0 = bits 7:0 |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 15 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | 2 | Lane selects, active low, bit 0 = low byte |
| sram_dq_out | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | 16 | Data from the memory |

## Verification
Two things can happen in the same cycle. The done pulse of a finished write appears in its idle cycle, and a new request can be accepted in that same cycle. The same is true of a zero-mask access and the request that follows it. The bench provokes this by holding `req` high across long runs of back-to-back writes, reads and empty-mask accesses. Its per-cycle model then predicts both the done pulse and the pin changes of the next access in the following cycle. It also sends reads straight into writes while the request is held high. This checks that the quiet cycle stays free of drive, and that changes to the request while the sequencer is busy never reach the memory pins.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_READ   = 3'd1,
        PH_TURN   = 3'd2,
        PH_WSETUP = 3'd3,
        PH_WPULSE = 3'd4,
        PH_WHOLD  = 3'd5
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
        logic lanes_on;
    } pin_ctl_t;

    function automatic int div_up(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // access time per speed grade, ns
    function automatic int access_ns(input int grade);
        case (grade)
            0:       return 10;
            1:       return 12;
            2:       return 15;
            default: return 20;
        endcase
    endfunction

    function automatic int we_pulse_ns(input int grade);
        case (grade)
            0:       return 7;
            1:       return 8;
            2:       return 10;
            default: return 12;
        endcase
    endfunction

    function automatic int data_setup_ns(input int grade);
        case (grade)
            0:       return 5;
            1:       return 6;
            2:       return 7;
            default: return 8;
        endcase
    endfunction

    // one extra cycle of margin for the asynchronous data path
    function automatic int read_cycles(input int grade, input int clk_ns);
        return div_up(access_ns(grade), clk_ns) + 1;
    endfunction

    function automatic int we_cycles(input int grade, input int clk_ns);
        int need;
        int cyc;
        need = (we_pulse_ns(grade) > data_setup_ns(grade)) ?
               we_pulse_ns(grade) : data_setup_ns(grade);
        cyc  = div_up(need, clk_ns);
        return (cyc < 1) ? 1 : cyc;
    endfunction

    function automatic pin_ctl_t pins_for(input phase_e ph);
        pin_ctl_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0, lanes_on: 1'b0};
        case (ph)
            PH_READ: begin
                p.ce_n = 1'b0; p.oe_n = 1'b0; p.lanes_on = 1'b1;
            end
            PH_WSETUP, PH_WHOLD: begin
                p.ce_n = 1'b0; p.lanes_on = 1'b1;
            end
            PH_WPULSE: begin
                p.ce_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; p.lanes_on = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lanes_on_d,
    input  logic [LANES-1:0]   mask_d,
    input  logic               capture,
    input  logic [8*LANES-1:0] din,
    output logic [LANES-1:0]   be_n,
    output logic [8*LANES-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic       sel_n_q;
        logic [7:0] dat_q;

        always_ff @(posedge clk) begin
            if (rst) sel_n_q <= 1'b1;
            else     sel_n_q <= ~(lanes_on_d & mask_d[i]);
        end

        // a lane left out of the access returns zero
        always_ff @(posedge clk) begin
            if (rst)          dat_q <= '0;
            else if (capture) dat_q <= sel_n_q ? 8'h00 : din[8*i +: 8];
        end

        assign be_n[i]          = sel_n_q;
        assign dout[8*i +: 8]   = dat_q;
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16,
    parameter int CLK_NS = 20,
    parameter int GRADE  = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W/8-1:0]  req_mask,
    output logic                 ready,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic [ADDR_W-1:0]    sram_addr,
    output logic                 sram_ce_n,
    output logic                 sram_we_n,
    output logic                 sram_oe_n,
    output logic [DATA_W/8-1:0]  sram_be_n,
    output logic [DATA_W-1:0]    sram_dq_out,
    output logic                 sram_dq_oe,
    input  logic [DATA_W-1:0]    sram_dq_in
);
    localparam int LANES   = DATA_W / 8;
    localparam int RD_CYC  = read_cycles(GRADE, CLK_NS);
    localparam int WE_CYC  = we_cycles(GRADE, CLK_NS);
    localparam int MAX_CYC = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    phase_e              ph_q, ph_d;
    pin_ctl_t            pins_q, pins_d;
    logic                accept, tmr_load, tmr_zero, capture, done_d, done_q;
    logic [CNT_W-1:0]    tmr_val;
    logic [LANES-1:0]    mask_q, mask_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;

    sram_phase_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        ph_d     = ph_q;
        accept   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        done_d   = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (req_mask == '0) begin
                        done_d = 1'b1;
                    end else if (req_we) begin
                        ph_d = PH_WSETUP;
                    end else begin
                        ph_d     = PH_READ;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_READ: begin
                if (tmr_zero) begin
                    capture = 1'b1;
                    done_d  = 1'b1;
                    ph_d    = PH_TURN;
                end
            end
            PH_TURN:   ph_d = PH_IDLE;
            PH_WSETUP: begin
                ph_d     = PH_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WE_CYC - 1);
            end
            PH_WPULSE: if (tmr_zero) ph_d = PH_WHOLD;
            PH_WHOLD: begin
                ph_d   = PH_IDLE;
                done_d = 1'b1;
            end
            default:   ph_d = PH_IDLE;
        endcase
    end

    assign pins_d = pins_for(ph_d);
    assign mask_d = accept ? req_mask : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            pins_q <= pins_for(PH_IDLE);
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            pins_q <= pins_d;
            done_q <= done_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    sram_lane_ctrl #(.LANES(LANES)) u_lanes (
        .clk        (clk),
        .rst        (rst),
        .lanes_on_d (pins_d.lanes_on),
        .mask_d     (mask_d),
        .capture    (capture),
        .din        (sram_dq_in),
        .be_n       (sram_be_n),
        .dout       (rdata)
    );

    assign ready       = (ph_q == PH_IDLE);
    assign done        = done_q;
    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;
    assign sram_ce_n   = pins_q.ce_n;
    assign sram_oe_n   = pins_q.oe_n;
    assign sram_we_n   = pins_q.we_n;
    assign sram_dq_oe  = pins_q.drive;

    // R4
    we_fall_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> $past(!sram_ce_n && sram_we_n));

    // R4
    we_ends_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (!sram_ce_n && (sram_be_n != '1)));

    // R5
    drive_only_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> (sram_oe_n && !sram_ce_n && !sram_we_n));

    // R6
    addr_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out) && $stable(sram_be_n)));

    // R7
    turn_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (!ready && !sram_dq_oe && sram_ce_n && done));

    // R8
    no_done_mid_access_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && !sram_ce_n) |-> !done);

    // R9
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && req && (req_mask == '0)) |=> (sram_ce_n && done && ready));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
    localparam int AW = 15;
    localparam int DW = 16;
    localparam int LN = 2;
    localparam int CLK_NS = 20;
    localparam int T_ACC = 10;
    localparam int T_PW  = 7;
    localparam int T_DS  = 5;
    localparam int RD_EXP = (T_ACC + CLK_NS - 1) / CLK_NS + 1;
    localparam int WE_EXP = (((T_PW > T_DS) ? T_PW : T_DS) + CLK_NS - 1) / CLK_NS;

    localparam int K_IDLE = 0, K_RD = 1, K_TURN = 2, K_WR = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [LN-1:0] req_mask = '0;
    logic ready, done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] sram_addr;
    logic sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [LN-1:0] sram_be_n;
    logic [DW-1:0] sram_dq_out;
    logic [DW-1:0] sram_dq_in = 16'hB00B;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_NS), .GRADE(0)) dut_i (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .ready(ready), .done(done),
        .rdata(rdata), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    logic [15:0] chip_mem [int];
    logic [15:0] ref_mem  [int];

    function automatic logic [15:0] fill(input int a);
        return 16'((a * 40503) ^ 16'h3C5A);
    endfunction

    function automatic logic [15:0] chip_rd(input int a);
        return chip_mem.exists(a) ? chip_mem[a] : fill(a);
    endfunction

    function automatic logic [15:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : fill(a);
    endfunction

    // behavioural memory: stores while selected with write strobe low,
    // drives selected lanes while output enabled, junk on unselected lanes
    always @(negedge clk) begin
        logic [15:0] w;
        if (!sram_ce_n && !sram_we_n) begin
            w = chip_rd(int'(sram_addr));
            for (int l = 0; l < LN; l++)
                if (!sram_be_n[l] && sram_dq_oe) w[8*l +: 8] = sram_dq_out[8*l +: 8];
            chip_mem[int'(sram_addr)] = w;
        end
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            w = chip_rd(int'(sram_addr));
            for (int l = 0; l < LN; l++)
                if (sram_be_n[l]) w[8*l +: 8] = 8'hEE;
            sram_dq_in = w;
        end else begin
            sram_dq_in = 16'hB00B;
        end
    end

    // reference model, advanced on every clock
    int mk = K_IDLE;
    int ms = 0;
    bit m_done = 0;
    bit m_rd = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic [LN-1:0] m_mask = '0;
    logic [DW-1:0] m_rdata = '0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mk = K_IDLE; ms = 0; m_done = 0;
        end else begin
            m_done = 0;
            case (mk)
                K_IDLE: if (req) begin
                    m_addr = req_addr; m_wdata = req_wdata; m_mask = req_mask;
                    m_rd = 0;
                    if (req_mask == '0) begin
                        m_done = 1;
                    end else if (req_we) begin
                        logic [15:0] w;
                        w = ref_rd(int'(req_addr));
                        for (int l = 0; l < LN; l++)
                            if (req_mask[l]) w[8*l +: 8] = req_wdata[8*l +: 8];
                        ref_mem[int'(req_addr)] = w;
                        mk = K_WR; ms = 0;
                    end else begin
                        mk = K_RD; ms = 0; m_rd = 1;
                    end
                end
                K_RD: begin
                    if (ms == RD_EXP - 1) begin
                        logic [15:0] w;
                        w = ref_rd(int'(m_addr));
                        for (int l = 0; l < LN; l++)
                            if (!m_mask[l]) w[8*l +: 8] = 8'h00;
                        m_rdata = w; m_done = 1; mk = K_TURN;
                    end else ms++;
                end
                K_TURN: mk = K_IDLE;
                K_WR: begin
                    if (ms == WE_EXP + 1) begin
                        mk = K_IDLE; m_done = 1;
                    end else ms++;
                end
                default: mk = K_IDLE;
            endcase
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp_v,
                       input string tag, input string what);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp_v);
        end
    endtask

    always @(negedge clk) begin
        if (cyc > 0) begin
            string ph;
            bit e_ce, e_oe, e_we;
            logic [LN-1:0] e_be;
            ph   = rst ? "R1" : (mk == K_RD) ? "R2" : (mk == K_WR) ? "R4" :
                   (mk == K_TURN) ? "R7" : "R9";
            e_ce = !(mk == K_RD || mk == K_WR);
            e_oe = !(mk == K_RD);
            e_we = !(mk == K_WR && ms >= 1 && ms <= WE_EXP);
            e_be = (mk == K_RD || mk == K_WR) ? ~m_mask : '1;
            chk(32'(ready), 32'(mk == K_IDLE), rst ? "R1" : "R8", "ready");
            chk(32'(done), 32'(m_done), rst ? "R1" : "R8", "done");
            chk(32'(sram_ce_n), 32'(e_ce), ph, "ce_n");
            chk(32'(sram_oe_n), 32'(e_oe), (mk == K_RD) ? "R11" : ph, "oe_n");
            chk(32'(sram_we_n), 32'(e_we), (mk == K_WR) ? "R11" : ph, "we_n");
            chk(32'(sram_be_n), 32'(e_be), rst ? "R1" : "R10", "be_n");
            chk(32'(sram_dq_oe), 32'(!e_we), rst ? "R1" : "R5", "dq_oe");
            if (!e_ce) chk(32'(sram_addr), 32'(m_addr), "R6", "addr");
            if (!e_we) chk(32'(sram_dq_out), 32'(m_wdata), "R6", "dq_out");
            if (m_done && m_rd && !rst) chk(32'(rdata), 32'(m_rdata), "R3", "rdata");
        end
    end

    // called at a falling edge; keeps req high so calls can run back to back
    task automatic issue(input bit we, input int a, input logic [15:0] d, input logic [1:0] m);
        req = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = d; req_mask = m;
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pause(input int n);
        req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        pause(2);
        // R4 R10 writes of both lanes, low lane, high lane
        issue(1, 5, 16'hA1B2, 2'b11);
        issue(1, 6, 16'h1111, 2'b01);
        issue(1, 7, 16'h2222, 2'b10);
        pause(2);
        // R2 R3 reads with each mask
        issue(0, 5, 16'h0, 2'b11);
        issue(0, 6, 16'h0, 2'b01);
        issue(0, 7, 16'h0, 2'b10);
        issue(0, 6, 16'h0, 2'b11);
        // R9 empty masks, write then read
        issue(1, 6, 16'hFFFF, 2'b00);
        issue(0, 6, 16'h0, 2'b00);
        issue(0, 6, 16'h0, 2'b11);
        // R7 read immediately followed by write
        issue(0, 5, 16'h0, 2'b11);
        issue(1, 5, 16'h5A5A, 2'b11);
        issue(0, 5, 16'h0, 2'b11);
        pause(1);
        // R8 high end of the address space and mixed traffic
        issue(1, 32767, 16'hBEEF, 2'b11);
        issue(0, 32767, 16'h0, 2'b10);
        for (int i = 0; i < 400; i++) begin
            bit we;
            int a;
            we = $urandom_range(0, 1) == 1;
            a  = ($urandom_range(0, 3) == 0) ? (32752 + $urandom_range(0, 15)) : $urandom_range(0, 15);
            issue(we, a, 16'($urandom), 2'($urandom_range(0, 3)));
            if ($urandom_range(0, 7) == 0) pause($urandom_range(1, 3));
        end
        pause(6);
        finish_run();
    end
endmodule